// File: doc/BRIEF.md
# Prioritized Interrupt Recognition and Vectoring

This block is the interrupt front end of a small 8-bit processor. It takes 29 maskable peripheral request lines and the three nonmaskable sources: the illegal-opcode trap, the software interrupt and the external XIRQ level. The maskable lines fold onto 17 maskable vectors, and several lines share each vector. Each maskable line is qualified by its own enable where it has one, and then by the global I mask. XIRQ is qualified only by the X mask. The trap and the software interrupt are never masked.

The processor raises `instr_done` at each instruction boundary. At that boundary the block takes the highest-priority pending source, pulses `irq_take` and presents the vector fetch address. The processor then stacks its registers and raises `ccr_stacked` once the condition codes are on the stack. One cycle later the block pulses `set_i_pulse`, and also `set_x_pulse` when XIRQ was the source taken. The block keeps the I and X mask bits itself. Software may set or clear I, and may clear X. Only an XIRQ service or reset sets X again.

Top module: `irq_front`

## Requirements
- R1: After reset, `i_mask` and `x_mask` are 1, and `irq_take`, `set_i_pulse` and `set_x_pulse` are 0.
- R2: Maskable line s belongs to maskable vector s mod 17. A vector is pending when any of its lines is requested and enabled. Lines 0 to 25 have a local enable bit in `src_en`. Lines 26 to 28 have none and count as always enabled.
- R3: No maskable vector is taken while `i_mask` is 1. A request held across a clear of I is taken at the next boundary.
- R4: XIRQ (`xirq_req`, level, active high) is taken only while `x_mask` is 0, whatever the value of `i_mask`.
- R5: `trap_req` and `swi_req` are taken regardless of both mask bits.
- R6: A take happens only on a cycle with `instr_done` high and some source pending. `irq_take` is high for exactly the one cycle after that edge. Further `instr_done` strobes are ignored until the `ccr_stacked` handshake completes.
- R7: Priority uses a vector index: maskable vector v has index v, XIRQ 17, software interrupt 18, trap 19. The highest pending index wins.
- R8: `vec_addr` equals 0xFFC0 + 2 × index of the source taken. It is valid with `irq_take` and stays stable until the mask pulses.
- R9: The cycle after `ccr_stacked` is sampled, `set_i_pulse` is 1 and `i_mask` reads 1. `set_x_pulse` is 1 and `x_mask` reads 1 only if the source taken was XIRQ.
- R10: `sw_set_i` sets I and `sw_clr_i` clears it. `sw_clr_x` clears X. X is never set except through `set_x_pulse` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 29 | Maskable peripheral request lines |
| src_en | input | 29 | Local enables (bits 0..25 used) |
| xirq_req | input | 1 | External nonmaskable request, level |
| swi_req | input | 1 | Software interrupt request |
| trap_req | input | 1 | Illegal-opcode trap request |
| instr_done | input | 1 | Instruction boundary strobe |
| ccr_stacked | input | 1 | Condition codes pushed strobe |
| sw_set_i | input | 1 | Software sets I |
| sw_clr_i | input | 1 | Software clears I |
| sw_clr_x | input | 1 | Software clears X |
| irq_take | output | 1 | One-cycle take pulse |
| vec_addr | output | 16 | Vector fetch address |
| set_i_pulse | output | 1 | I being set by the sequence |
| set_x_pulse | output | 1 | X being set by the sequence |
| i_mask | output | 1 | Current I mask bit |
| x_mask | output | 1 | Current X mask bit |

## Verification
On every cycle the assertions check these rules: a take only follows a boundary, a maskable take never follows a set I, the winner is the highest pending index, the vector address holds during service, and X rises only with its pulse after an XIRQ service. The bench scenarios cover the rest. They show the grouping of shared lines and the effect of local enables, with random request patterns checked against a reference pick. They also show I being cleared under a waiting request, XIRQ served while I is set, and the exact values of the address and the mask state after each handshake.

// File: rtl/irq_pkg.sv
// Package irq_pkg: constants and types shared by the interrupt front end.
// Assumes a 16-bit address space with the vector table ending at 0xFFFF.
package irq_pkg;
    localparam logic [15:0] VEC_BASE = 16'hFFC0;

    // Service sequence states: idle, or waiting for condition codes stacked
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_t;
endpackage

// File: rtl/irq_qualify.sv
// Module irq_qualify: gates every source with its masks and folds the
// maskable lines onto their vectors. Line s feeds maskable vector
// s mod N_MVEC. Lines whose bit in EN_PRESENT is 0 have no local enable.
// Output bit order is the priority index: maskable vectors first, then
// XIRQ, software interrupt and trap.
module irq_qualify #(
    parameter int N_MSRC = 29,
    parameter int N_MVEC = 17,
    parameter logic [N_MSRC-1:0] EN_PRESENT = '1,
    localparam int N_VEC = N_MVEC + 3
) (
    input  logic [N_MSRC-1:0] src_req,
    input  logic [N_MSRC-1:0] src_en,
    input  logic              i_mask,
    input  logic              x_mask,
    input  logic              xirq_req,
    input  logic              swi_req,
    input  logic              trap_req,
    output logic [N_VEC-1:0]  pend
);
    logic [N_MSRC-1:0] line_ok;
    logic [N_MVEC-1:0] mvec_raw;

    // One qualifier per line; the parameter picks the variant
    for (genvar s = 0; s < N_MSRC; s++) begin : g_line
        if (EN_PRESENT[s]) begin : g_en
            assign line_ok[s] = src_req[s] & src_en[s];
        end else begin : g_noen
            assign line_ok[s] = src_req[s];
        end
    end

    // Fold the lines onto their shared vectors
    for (genvar v = 0; v < N_MVEC; v++) begin : g_vec
        always_comb begin
            mvec_raw[v] = 1'b0;
            for (int s = v; s < N_MSRC; s += N_MVEC) begin
                mvec_raw[v] = mvec_raw[v] | line_ok[s];
            end
        end
    end

    // Apply the global masks and place the nonmaskable sources
    always_comb begin
        pend = '0;
        pend[N_MVEC-1:0] = i_mask ? '0 : mvec_raw;
        pend[N_MVEC]     = xirq_req & ~x_mask;
        pend[N_MVEC+1]   = swi_req;
        pend[N_MVEC+2]   = trap_req;
    end
endmodule

// File: rtl/irq_prio.sv
// Module irq_prio: fixed-priority encoder in which the highest set index
// wins. Assumes pend is already fully qualified. clk and rst_n are used
// only by the embedded check.
module irq_prio #(
    parameter int N = 20,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pend,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan upward; the last hit is the highest index
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (pend[k]) begin
                any = 1'b1;
                idx = IW'(k);
            end
        end
    end

    AST_PRIO_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (pend[idx] && ((pend >> idx) >> 1) == '0)); // R7
endmodule

// File: rtl/irq_seq.sv
// Module irq_seq: takes a source at an instruction boundary, holds its
// vector through the stacking handshake, then issues the mask pulses and
// keeps the I and X bits. Assumes ccr_stacked arrives only after a take.
module irq_seq #(
    parameter int N_VEC = 20,
    parameter int IDX_XIRQ = 17,
    localparam int IW = $clog2(N_VEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_done,
    input  logic          ccr_stacked,
    input  logic          any,
    input  logic [IW-1:0] idx,
    input  logic          sw_set_i,
    input  logic          sw_clr_i,
    input  logic          sw_clr_x,
    output logic          irq_take,
    output logic [15:0]   vec_addr,
    output logic          set_i_pulse,
    output logic          set_x_pulse,
    output logic          i_mask,
    output logic          x_mask
);
    import irq_pkg::*;

    seq_state_t    state;
    logic [IW-1:0] idx_q;
    logic          finish;
    logic          took_xirq;

    assign finish    = (state == SEQ_WAIT) && ccr_stacked;
    assign took_xirq = (idx_q == IW'(IDX_XIRQ));

    // Boundary capture and the handshake state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SEQ_IDLE;
            idx_q       <= '0;
            irq_take    <= 1'b0;
            set_i_pulse <= 1'b0;
            set_x_pulse <= 1'b0;
        end else begin
            irq_take    <= 1'b0;
            set_i_pulse <= 1'b0;
            set_x_pulse <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (instr_done && any) begin
                        state    <= SEQ_WAIT;
                        idx_q    <= idx;
                        irq_take <= 1'b1;
                    end
                end
                SEQ_WAIT: begin
                    if (ccr_stacked) begin
                        state       <= SEQ_IDLE;
                        set_i_pulse <= 1'b1;
                        set_x_pulse <= took_xirq;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Mask bits: the sequence outranks software in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_mask <= 1'b1;
            x_mask <= 1'b1;
        end else if (finish) begin
            i_mask <= 1'b1;
            if (took_xirq) x_mask <= 1'b1;
        end else begin
            if (sw_set_i)      i_mask <= 1'b1;
            else if (sw_clr_i) i_mask <= 1'b0;
            if (sw_clr_x)      x_mask <= 1'b0;
        end
    end

    // Fetch address from the captured index
    assign vec_addr = VEC_BASE + (16'(idx_q) << 1);

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ($past(instr_done) && $past(any))); // R6
    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !irq_take); // R6
    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WAIT && !irq_take) |-> $stable(vec_addr)); // R8
    AST_SETI_AFTER_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        set_i_pulse |-> ($past(ccr_stacked) && i_mask)); // R9
    AST_SETX_ONLY_XIRQ: assert property (@(posedge clk) disable iff (!rst_n)
        set_x_pulse |-> (set_i_pulse && took_xirq && x_mask)); // R9
    AST_X_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(x_mask) |-> set_x_pulse); // R10
endmodule

// File: rtl/irq_front.sv
// Module irq_front: top of the interrupt front end. Qualifies the sources,
// picks the winner and runs the take and stacking handshake.
// Assumes the CPU raises instr_done only at instruction boundaries and
// ccr_stacked once per take.
module irq_front #(
    parameter int N_MSRC = 29,
    parameter int N_MVEC = 17,
    parameter logic [N_MSRC-1:0] EN_PRESENT = 29'h03FF_FFFF,
    localparam int N_VEC = N_MVEC + 3,
    localparam int IW = $clog2(N_VEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_MSRC-1:0] src_req,
    input  logic [N_MSRC-1:0] src_en,
    input  logic              xirq_req,
    input  logic              swi_req,
    input  logic              trap_req,
    input  logic              instr_done,
    input  logic              ccr_stacked,
    input  logic              sw_set_i,
    input  logic              sw_clr_i,
    input  logic              sw_clr_x,
    output logic              irq_take,
    output logic [15:0]       vec_addr,
    output logic              set_i_pulse,
    output logic              set_x_pulse,
    output logic              i_mask,
    output logic              x_mask
);
    import irq_pkg::*;

    logic [N_VEC-1:0] pend;
    logic             any;
    logic [IW-1:0]    idx;

    irq_qualify #(.N_MSRC(N_MSRC), .N_MVEC(N_MVEC), .EN_PRESENT(EN_PRESENT)) u_qual (
        .src_req(src_req), .src_en(src_en), .i_mask(i_mask), .x_mask(x_mask),
        .xirq_req(xirq_req), .swi_req(swi_req), .trap_req(trap_req), .pend(pend)
    );

    irq_prio #(.N(N_VEC)) u_prio (
        .clk(clk), .rst_n(rst_n), .pend(pend), .any(any), .idx(idx)
    );

    irq_seq #(.N_VEC(N_VEC), .IDX_XIRQ(N_MVEC)) u_seq (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .ccr_stacked(ccr_stacked),
        .any(any), .idx(idx), .sw_set_i(sw_set_i), .sw_clr_i(sw_clr_i),
        .sw_clr_x(sw_clr_x), .irq_take(irq_take), .vec_addr(vec_addr),
        .set_i_pulse(set_i_pulse), .set_x_pulse(set_x_pulse),
        .i_mask(i_mask), .x_mask(x_mask)
    );

    AST_MASKED_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && vec_addr < VEC_BASE + 16'(2 * N_MVEC)) |-> !$past(i_mask)); // R3
    AST_XIRQ_NEEDS_X_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && vec_addr == VEC_BASE + 16'(2 * N_MVEC)) |-> !$past(x_mask)); // R4
endmodule

// File: tb/sim_irq_front.sv
module sim_irq_front;
    localparam int CLK_PERIOD = 10;
    localparam int NM = 29;
    localparam int NV = 17;
    localparam logic [NM-1:0] HAS_EN = 29'h03FF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NM-1:0] src_req = '0, src_en = '0;
    logic xirq_req = 0, swi_req = 0, trap_req = 0, instr_done = 0, ccr_stacked = 0;
    logic sw_set_i = 0, sw_clr_i = 0, sw_clr_x = 0;
    logic irq_take, set_i_pulse, set_x_pulse, i_mask, x_mask;
    logic [15:0] vec_addr;

    int checks = 0, fails = 0;
    bit mi = 1, mx = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_front u0 (.*);

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pick(logic [NM-1:0] rq, logic [NM-1:0] en,
                                bit xi, bit sw, bit tr, bit i_m, bit x_m);
        if (tr) return 19;
        if (sw) return 18;
        if (xi && !x_m) return 17;
        if (!i_m)
            for (int v = NV - 1; v >= 0; v--)
                for (int s = v; s < NM; s += NV)
                    if (rq[s] && (en[s] || !HAS_EN[s])) return v;
        return -1;
    endfunction

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic sw_op(bit set_i, bit clr_i, bit clr_x);
        sw_set_i = set_i; sw_clr_i = clr_i; sw_clr_x = clr_x;
        step();
        sw_set_i = 0; sw_clr_i = 0; sw_clr_x = 0;
        if (set_i) mi = 1; else if (clr_i) mi = 0;
        if (clr_x) mx = 0;
        chk(i_mask == mi, "R10 i_mask", i_mask, mi);
        chk(x_mask == mx, "R10 x_mask", x_mask, mx);
    endtask

    // Apply a pattern at a boundary, then run the full handshake if taken
    task automatic boundary(logic [NM-1:0] rq, logic [NM-1:0] en,
                            bit xi, bit sw, bit tr, string req);
        int e;
        e = pick(rq, en, xi, sw, tr, mi, mx);
        src_req = rq; src_en = en; xirq_req = xi; swi_req = sw; trap_req = tr;
        instr_done = 1;
        step();
        instr_done = 0;
        chk(irq_take == (e >= 0), {req, " take"}, irq_take, e >= 0);
        if (e >= 0) begin
            chk(vec_addr == 16'hFFC0 + 16'(2 * e), {req, " R8 vec_addr"}, vec_addr, 16'hFFC0 + 2 * e);
            instr_done = 1;                      // ignored during service (R6)
            step();
            instr_done = 0;
            chk(irq_take == 0, "R6 no retake while waiting", irq_take, 0);
            chk(vec_addr == 16'hFFC0 + 16'(2 * e), "R8 vec held", vec_addr, 16'hFFC0 + 2 * e);
            ccr_stacked = 1;
            step();
            ccr_stacked = 0;
            mi = 1;
            if (e == 17) mx = 1;
            chk(set_i_pulse == 1, "R9 set_i_pulse", set_i_pulse, 1);
            chk(set_x_pulse == (e == 17), "R9 set_x_pulse", set_x_pulse, e == 17);
            chk(i_mask == mi && x_mask == mx, "R9 masks", {i_mask, x_mask}, {mi, mx});
            step();
            chk(!set_i_pulse && !set_x_pulse, "R9 pulses single", {set_i_pulse, set_x_pulse}, 0);
        end
        src_req = '0; xirq_req = 0; swi_req = 0; trap_req = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        step(); step();
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(i_mask && x_mask, "R1 masks after reset", {i_mask, x_mask}, 3);
        chk(!irq_take && !set_i_pulse && !set_x_pulse, "R1 outputs idle",
            {irq_take, set_i_pulse, set_x_pulse}, 0);
        // R3 masked maskable request, then unmasked
        boundary(29'h1 << 5, 29'h1 << 5, 0, 0, 0, "R3 masked");
        sw_op(0, 1, 0);
        boundary(29'h1 << 5, 29'h1 << 5, 0, 0, 0, "R3 unmasked");
        // R2 shared vector: line 20 alone lands on vector 3
        sw_op(0, 1, 0);
        boundary(29'h1 << 20, 29'h1 << 20, 0, 0, 0, "R2 shared line");
        // R2 line without local enable (27 -> vector 10), enable low
        sw_op(0, 1, 0);
        boundary(29'h1 << 27, '0, 0, 0, 0, "R2 no local enable");
        // R2 enabled line with enable low is ignored
        sw_op(0, 1, 0);
        boundary(29'h1 << 4, '0, 0, 0, 0, "R2 local enable off");
        // R4 XIRQ with X set not taken, then I set and X clear: taken
        sw_op(1, 0, 0);
        boundary('0, '0, 1, 0, 0, "R4 xirq X set");
        sw_op(0, 0, 1);
        boundary('0, '0, 1, 0, 0, "R4 xirq I set X clear");
        // R5/R7 all nonmaskable together with masks set: trap wins
        boundary('1, '1, 1, 1, 1, "R5 R7 trap first");
        boundary('0, '0, 1, 1, 0, "R5 R7 swi over xirq");
        // R7 simultaneous maskable vectors
        sw_op(0, 1, 0);
        boundary(29'h0001_0101, '1, 0, 0, 0, "R7 simultaneous");
        // Random patterns
        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom_range(0, 3);
            if (r == 0) sw_op(1, 0, 0);
            else if (r != 3) sw_op(0, 1, 0);
            if ($urandom_range(0, 4) == 0) sw_op(0, 0, 1);
            boundary(NM'($urandom) & NM'($urandom), NM'($urandom),
                     $urandom_range(0, 3) == 0, $urandom_range(0, 9) == 0,
                     $urandom_range(0, 9) == 0, "R7 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule